// File: doc/BRIEF.md
# ALU Reservation Station with Operand Capture

This block holds ALU instructions that have been issued but cannot execute yet. It has a fixed number of slots. Each new instruction goes into a free slot, and the slot then gathers the source operands the instruction needs.

Operands arrive in three ways:

- The cycle after a slot accepts an instruction, it reads the register-file lookup result for each source it uses. It takes the register value if that register has no pending writer.
- If the register has a pending writer, the slot takes the value held in the reorder buffer, when the buffer has it.
- Failing both, the slot keeps the producer tag from the register file. It then watches the result broadcasts from the ALU and from the memory unit until the matching tag appears.

Each slot moves through three states: empty, fresh (accepted last edge), and waiting. Once every used operand of a waiting slot is present, the slot is ready. Each cycle, the ready slot with the lowest index is sent to the ALU through a registered dispatch port. That port carries the operation id, both operands, the immediate, the PC and the reorder tag, and the slot becomes empty again. A dispatched operation id of zero means nothing was sent.

The block also reports how many slots are empty. The issuing stage uses this count to decide whether it may issue. A flush input empties every slot at once.

Top module: `alu_resv_station`

## Requirements
- R1: After reset, `free_count` equals SLOTS and `disp_op` is zero.
- R2: An instruction offered on `issue_valid` while a slot is empty is accepted. `free_count` drops by one after that edge.
- R3: An instruction offered while no slot is empty is ignored. `free_count` stays zero and the instruction is never dispatched.
- R4: In the cycle after acceptance, a used source whose register-file clear flag (`rf_*_clear`) is 1 takes the register-file value. This holds even when the reorder buffer also reports a hit.
- R5: In that cycle, a used source whose clear flag is 0 and whose reorder-buffer hit (`rob_*_hit`) is 1 takes the reorder-buffer value.
- R6: In that cycle, a used source with neither flag records `rf_*_tag` as its producer and waits. A result broadcast in that same cycle whose tag equals `rf_*_tag` fills the source immediately.
- R7: A result broadcast fills every waiting source whose producer tag matches, from the ALU or the memory unit alike, but only when its status equals 2'b10. Any other status has no effect.
- R8: A source whose use flag was 0 at issue needs no operand and is dispatched as zero.
- R9: An instruction is dispatched on the second edge after acceptance at the earliest. All dispatch outputs are registered, and the ready slot with the lowest index is dispatched first.
- R10: In a cycle with nothing to dispatch, `disp_op` and the other dispatch outputs are zero. Issued operation ids must therefore be nonzero.
- R11: `free_count` always equals the number of empty slots, and it rises by one after each dispatch.
- R12: `flush` empties every slot, sets `free_count` to SLOTS and zeroes the dispatch outputs on the next edge. Nothing captured before the flush is dispatched afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Empty all slots |
| issue_valid | input | 1 | New instruction offered |
| issue_op | input | OP_W | Decoded operation id, nonzero |
| issue_imm | input | DATA_W | Immediate |
| issue_pc | input | DATA_W | Instruction PC |
| issue_tag | input | TAG_W | Reorder tag of the instruction |
| issue_use_a | input | 1 | Source A is used |
| issue_use_b | input | 1 | Source B is used |
| rf_a_clear | input | 1 | Source A register has no pending writer |
| rf_a_val | input | DATA_W | Register value for source A |
| rf_a_tag | input | TAG_W | Pending producer tag for source A |
| rf_b_clear | input | 1 | Source B register has no pending writer |
| rf_b_val | input | DATA_W | Register value for source B |
| rf_b_tag | input | TAG_W | Pending producer tag for source B |
| rob_a_hit | input | 1 | Reorder buffer holds source A result |
| rob_a_val | input | DATA_W | Reorder-buffer value for source A |
| rob_b_hit | input | 1 | Reorder buffer holds source B result |
| rob_b_val | input | DATA_W | Reorder-buffer value for source B |
| alu_res_status | input | 2 | ALU broadcast status, 2'b10 is valid |
| alu_res_tag | input | TAG_W | ALU broadcast tag |
| alu_res_val | input | DATA_W | ALU broadcast value |
| mem_res_status | input | 2 | Memory broadcast status, 2'b10 is valid |
| mem_res_tag | input | TAG_W | Memory broadcast tag |
| mem_res_val | input | DATA_W | Memory broadcast value |
| disp_op | output | OP_W | Dispatched operation id, zero when idle |
| disp_a | output | DATA_W | Source A operand |
| disp_b | output | DATA_W | Source B operand |
| disp_imm | output | DATA_W | Immediate |
| disp_pc | output | DATA_W | PC |
| disp_tag | output | TAG_W | Reorder tag |
| free_count | output | $clog2(SLOTS+1) | Number of empty slots |

## Verification
The hardest case to reach is a broadcast that lands in the very cycle a fresh slot resolves its sources. That slot has not stored any tag yet, so it must compare the broadcast against the register-file tag on its inputs. The stimulus drives an ALU broadcast alongside the register-file answer in the cycle right after issue.

A full station is the other awkward state. The bench fills all slots with instructions that wait on one tag that is never broadcast. It then offers one more instruction, which must be ignored, and flushes. Finally it broadcasts the stale tag, which must dispatch nothing.

// File: rtl/rs_pkg.sv
package rs_pkg;
   typedef enum logic [1:0] {
      SLOT_EMPTY = 2'd0,
      SLOT_FRESH = 2'd1,
      SLOT_WAIT  = 2'd2
   } slot_state_e;

   localparam logic [1:0] BCAST_VALID = 2'b10;
endpackage

// File: rtl/rs_pick_low.sv
module rs_pick_low #(
   parameter int N  = 32,
   parameter int IW = 5
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx
);
   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IW'(i);
         end
      end
   end
endmodule

// File: rtl/rs_free_count.sv
module rs_free_count #(
   parameter int SLOTS = 32,
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             dec,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= CNT_W'(SLOTS);
      else if (flush) count <= CNT_W'(SLOTS);
      else            count <= count + CNT_W'(inc) - CNT_W'(dec);
   end
endmodule

// File: rtl/rs_slot.sv
module rs_slot
   import rs_pkg::*;
#(
   parameter int OP_W   = 12,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   flush,
   input  logic                   alloc,
   input  logic                   take,
   input  logic [OP_W-1:0]        in_op,
   input  logic [DATA_W-1:0]      in_imm,
   input  logic [DATA_W-1:0]      in_pc,
   input  logic [TAG_W-1:0]       in_tag,
   input  logic [1:0]             in_used,
   input  logic [1:0]             rf_clear,
   input  logic [1:0][DATA_W-1:0] rf_val,
   input  logic [1:0][TAG_W-1:0]  rf_tag,
   input  logic [1:0]             rob_hit,
   input  logic [1:0][DATA_W-1:0] rob_val,
   input  logic                   alu_ok,
   input  logic [TAG_W-1:0]       alu_tag,
   input  logic [DATA_W-1:0]      alu_val,
   input  logic                   mem_ok,
   input  logic [TAG_W-1:0]       mem_tag,
   input  logic [DATA_W-1:0]      mem_val,
   output logic                   is_empty,
   output logic                   is_fresh,
   output logic                   is_ready,
   output logic [OP_W-1:0]        op,
   output logic [DATA_W-1:0]      imm,
   output logic [DATA_W-1:0]      pc,
   output logic [TAG_W-1:0]       tag,
   output logic [1:0][DATA_W-1:0] opnd
);
   slot_state_e state;
   logic [1:0]  used;
   logic [1:0]  have;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= SLOT_EMPTY;
         used  <= '0;
         op    <= '0;
         imm   <= '0;
         pc    <= '0;
         tag   <= '0;
      end else if (flush) begin
         state <= SLOT_EMPTY;
      end else if (alloc) begin
         state <= SLOT_FRESH;
         used  <= in_used;
         op    <= in_op;
         imm   <= in_imm;
         pc    <= in_pc;
         tag   <= in_tag;
      end else if (state == SLOT_FRESH) begin
         state <= SLOT_WAIT;
      end else if (state == SLOT_WAIT && take) begin
         state <= SLOT_EMPTY;
      end
   end

   for (genvar j = 0; j < 2; j++) begin : g_src
      logic              rdy_q;
      logic [TAG_W-1:0]  dep_q;
      logic [DATA_W-1:0] val_q;
      logic              alu_rf, mem_rf, alu_dep, mem_dep;

      assign alu_rf  = alu_ok && (alu_tag == rf_tag[j]);
      assign mem_rf  = mem_ok && (mem_tag == rf_tag[j]);
      assign alu_dep = alu_ok && (alu_tag == dep_q);
      assign mem_dep = mem_ok && (mem_tag == dep_q);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdy_q <= 1'b0;
            dep_q <= '0;
            val_q <= '0;
         end else if (alloc) begin
            rdy_q <= 1'b1;
            dep_q <= '0;
            val_q <= '0;
         end else if (state == SLOT_FRESH && used[j]) begin
            if (rf_clear[j])  val_q <= rf_val[j];
            else if (rob_hit[j]) val_q <= rob_val[j];
            else if (alu_rf)  val_q <= alu_val;
            else if (mem_rf)  val_q <= mem_val;
            else begin
               rdy_q <= 1'b0;
               dep_q <= rf_tag[j];
            end
         end else if (state == SLOT_WAIT && used[j] && !rdy_q) begin
            if (alu_dep) begin
               val_q <= alu_val;
               rdy_q <= 1'b1;
            end else if (mem_dep) begin
               val_q <= mem_val;
               rdy_q <= 1'b1;
            end
         end
      end

      assign have[j] = !used[j] || rdy_q;
      assign opnd[j] = val_q;
   end

   assign is_empty = (state == SLOT_EMPTY);
   assign is_fresh = (state == SLOT_FRESH);
   assign is_ready = (state == SLOT_WAIT) && (&have);
endmodule

// File: rtl/alu_resv_station.sv
module alu_resv_station
   import rs_pkg::*;
#(
   parameter int SLOTS  = 32,
   parameter int OP_W   = 12,
   parameter int DATA_W = 32,
   parameter int TAG_W  = 5,
   localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int CNT_W = $clog2(SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              issue_valid,
   input  logic [OP_W-1:0]   issue_op,
   input  logic [DATA_W-1:0] issue_imm,
   input  logic [DATA_W-1:0] issue_pc,
   input  logic [TAG_W-1:0]  issue_tag,
   input  logic              issue_use_a,
   input  logic              issue_use_b,
   input  logic              rf_a_clear,
   input  logic [DATA_W-1:0] rf_a_val,
   input  logic [TAG_W-1:0]  rf_a_tag,
   input  logic              rf_b_clear,
   input  logic [DATA_W-1:0] rf_b_val,
   input  logic [TAG_W-1:0]  rf_b_tag,
   input  logic              rob_a_hit,
   input  logic [DATA_W-1:0] rob_a_val,
   input  logic              rob_b_hit,
   input  logic [DATA_W-1:0] rob_b_val,
   input  logic [1:0]        alu_res_status,
   input  logic [TAG_W-1:0]  alu_res_tag,
   input  logic [DATA_W-1:0] alu_res_val,
   input  logic [1:0]        mem_res_status,
   input  logic [TAG_W-1:0]  mem_res_tag,
   input  logic [DATA_W-1:0] mem_res_val,
   output logic [OP_W-1:0]   disp_op,
   output logic [DATA_W-1:0] disp_a,
   output logic [DATA_W-1:0] disp_b,
   output logic [DATA_W-1:0] disp_imm,
   output logic [DATA_W-1:0] disp_pc,
   output logic [TAG_W-1:0]  disp_tag,
   output logic [CNT_W-1:0]  free_count
);
   if (SLOTS < 2) begin : g_bad_slots
      $error("alu_resv_station: SLOTS must be at least 2");
   end
   if (OP_W < 1 || TAG_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("alu_resv_station: widths must be positive");
   end

   logic [SLOTS-1:0]         slot_empty, slot_fresh, slot_ready;
   logic                     free_found, any_ready;
   logic [IDX_W-1:0]         free_idx, rdy_idx;
   logic                     do_alloc, do_disp;
   logic                     alu_ok, mem_ok;
   logic [1:0]               rf_clear_v, rob_hit_v, used_v;
   logic [1:0][DATA_W-1:0]   rf_val_v, rob_val_v;
   logic [1:0][TAG_W-1:0]    rf_tag_v;
   logic [OP_W-1:0]          s_op  [SLOTS];
   logic [DATA_W-1:0]        s_imm [SLOTS];
   logic [DATA_W-1:0]        s_pc  [SLOTS];
   logic [TAG_W-1:0]         s_tag [SLOTS];
   logic [1:0][DATA_W-1:0]   s_opnd[SLOTS];

   assign alu_ok     = (alu_res_status == BCAST_VALID);
   assign mem_ok     = (mem_res_status == BCAST_VALID);
   assign rf_clear_v = {rf_b_clear, rf_a_clear};
   assign rf_val_v   = {rf_b_val, rf_a_val};
   assign rf_tag_v   = {rf_b_tag, rf_a_tag};
   assign rob_hit_v  = {rob_b_hit, rob_a_hit};
   assign rob_val_v  = {rob_b_val, rob_a_val};
   assign used_v     = {issue_use_b, issue_use_a};

   rs_pick_low #(.N(SLOTS), .IW(IDX_W)) free_pick_i (
      .req(slot_empty), .found(free_found), .idx(free_idx));
   rs_pick_low #(.N(SLOTS), .IW(IDX_W)) rdy_pick_i (
      .req(slot_ready), .found(any_ready), .idx(rdy_idx));

   assign do_alloc = issue_valid && free_found && !flush;
   assign do_disp  = any_ready && !flush;

   for (genvar i = 0; i < SLOTS; i++) begin : g_slot
      rs_slot #(.OP_W(OP_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) slot_i (
         .clk(clk), .rst_n(rst_n), .flush(flush),
         .alloc(do_alloc && free_idx == IDX_W'(i)),
         .take(do_disp && rdy_idx == IDX_W'(i)),
         .in_op(issue_op), .in_imm(issue_imm), .in_pc(issue_pc),
         .in_tag(issue_tag), .in_used(used_v),
         .rf_clear(rf_clear_v), .rf_val(rf_val_v), .rf_tag(rf_tag_v),
         .rob_hit(rob_hit_v), .rob_val(rob_val_v),
         .alu_ok(alu_ok), .alu_tag(alu_res_tag), .alu_val(alu_res_val),
         .mem_ok(mem_ok), .mem_tag(mem_res_tag), .mem_val(mem_res_val),
         .is_empty(slot_empty[i]), .is_fresh(slot_fresh[i]),
         .is_ready(slot_ready[i]),
         .op(s_op[i]), .imm(s_imm[i]), .pc(s_pc[i]), .tag(s_tag[i]),
         .opnd(s_opnd[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_op  <= '0;
         disp_a   <= '0;
         disp_b   <= '0;
         disp_imm <= '0;
         disp_pc  <= '0;
         disp_tag <= '0;
      end else if (do_disp) begin
         disp_op  <= s_op[rdy_idx];
         disp_a   <= s_opnd[rdy_idx][0];
         disp_b   <= s_opnd[rdy_idx][1];
         disp_imm <= s_imm[rdy_idx];
         disp_pc  <= s_pc[rdy_idx];
         disp_tag <= s_tag[rdy_idx];
      end else begin
         disp_op  <= '0;
         disp_a   <= '0;
         disp_b   <= '0;
         disp_imm <= '0;
         disp_pc  <= '0;
         disp_tag <= '0;
      end
   end

   rs_free_count #(.SLOTS(SLOTS), .CNT_W(CNT_W)) free_cnt_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .dec(do_alloc), .inc(do_disp), .count(free_count));
endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
   parameter int SLOTS = 32,
   parameter int OP_W  = 12,
   parameter int CNT_W = 6
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flush,
   input logic [SLOTS-1:0] slot_empty,
   input logic [SLOTS-1:0] slot_fresh,
   input logic             any_ready,
   input logic [OP_W-1:0]  disp_op,
   input logic [CNT_W-1:0] free_count
);
   a_r11_free_matches_empty: assert property (@(posedge clk) disable iff (!rst_n)
      free_count == CNT_W'($countones(slot_empty)));

   a_r10_idle_dispatch_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (!any_ready || flush) |=> disp_op == '0);

   a_r12_flush_refills: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> free_count == CNT_W'(SLOTS));

   a_r3_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
      (free_count == '0 && !any_ready && !flush) |=> free_count == '0);

   a_r6_single_fresh: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(slot_fresh));
endmodule

bind alu_resv_station rs_checker #(.SLOTS(SLOTS), .OP_W(OP_W), .CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .flush(flush), .slot_empty(slot_empty),
   .slot_fresh(slot_fresh), .any_ready(any_ready), .disp_op(disp_op),
   .free_count(free_count));

// File: tb/alu_resv_station_tb.sv
`timescale 1ns/100ps
module alu_resv_station_tb_top;
   localparam int SLOTS = 32, OP_W = 12, DATA_W = 32, TAG_W = 5;
   localparam int CNT_W = $clog2(SLOTS + 1);

   logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
   logic issue_valid = 1'b0;
   logic [OP_W-1:0] issue_op = '0;
   logic [DATA_W-1:0] issue_imm = '0, issue_pc = '0;
   logic [TAG_W-1:0] issue_tag = '0;
   logic issue_use_a = 1'b0, issue_use_b = 1'b0;
   logic rf_a_clear = 1'b0, rf_b_clear = 1'b0;
   logic [DATA_W-1:0] rf_a_val = '0, rf_b_val = '0;
   logic [TAG_W-1:0] rf_a_tag = '0, rf_b_tag = '0;
   logic rob_a_hit = 1'b0, rob_b_hit = 1'b0;
   logic [DATA_W-1:0] rob_a_val = '0, rob_b_val = '0;
   logic [1:0] alu_res_status = '0, mem_res_status = '0;
   logic [TAG_W-1:0] alu_res_tag = '0, mem_res_tag = '0;
   logic [DATA_W-1:0] alu_res_val = '0, mem_res_val = '0;
   logic [OP_W-1:0] disp_op;
   logic [DATA_W-1:0] disp_a, disp_b, disp_imm, disp_pc;
   logic [TAG_W-1:0] disp_tag;
   logic [CNT_W-1:0] free_count;

   always #2.5 clk = ~clk;

   alu_resv_station #(.SLOTS(SLOTS), .OP_W(OP_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush), .issue_valid(issue_valid),
      .issue_op(issue_op), .issue_imm(issue_imm), .issue_pc(issue_pc),
      .issue_tag(issue_tag), .issue_use_a(issue_use_a), .issue_use_b(issue_use_b),
      .rf_a_clear(rf_a_clear), .rf_a_val(rf_a_val), .rf_a_tag(rf_a_tag),
      .rf_b_clear(rf_b_clear), .rf_b_val(rf_b_val), .rf_b_tag(rf_b_tag),
      .rob_a_hit(rob_a_hit), .rob_a_val(rob_a_val), .rob_b_hit(rob_b_hit),
      .rob_b_val(rob_b_val), .alu_res_status(alu_res_status),
      .alu_res_tag(alu_res_tag), .alu_res_val(alu_res_val),
      .mem_res_status(mem_res_status), .mem_res_tag(mem_res_tag),
      .mem_res_val(mem_res_val), .disp_op(disp_op), .disp_a(disp_a),
      .disp_b(disp_b), .disp_imm(disp_imm), .disp_pc(disp_pc),
      .disp_tag(disp_tag), .free_count(free_count));

   typedef struct {
      logic [OP_W-1:0]   op;
      logic [DATA_W-1:0] a, b, imm, pc;
      logic [TAG_W-1:0]  tag;
      string             req;
   } item_t;

   item_t exp_q[$];
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // monitor: every dispatch is compared with the next expected item
   always @(negedge clk) begin
      if (rst_n && disp_op != '0) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R3/R12", "unexpected dispatch op", 64'(disp_op), 64'h0);
         end else begin
            item_t e;
            e = exp_q.pop_front();
            chk(disp_op == e.op, e.req, "op", 64'(disp_op), 64'(e.op));
            chk(disp_a == e.a, e.req, "src a", 64'(disp_a), 64'(e.a));
            chk(disp_b == e.b, e.req, "src b", 64'(disp_b), 64'(e.b));
            chk(disp_imm == e.imm && disp_pc == e.pc, e.req, "imm/pc",
                {disp_imm, disp_pc}, {e.imm, e.pc});
            chk(disp_tag == e.tag, e.req, "tag", 64'(disp_tag), 64'(e.tag));
         end
      end
   end

   task automatic expect_item(input logic [OP_W-1:0] op, input logic [DATA_W-1:0] a,
                              input logic [DATA_W-1:0] b, input logic [DATA_W-1:0] imm,
                              input logic [DATA_W-1:0] pc, input logic [TAG_W-1:0] tag,
                              input string req);
      item_t e;
      e.op = op; e.a = a; e.b = b; e.imm = imm; e.pc = pc; e.tag = tag; e.req = req;
      exp_q.push_back(e);
   endtask

   // drives issue for one edge; returns at the negedge of the resolve cycle
   task automatic issue_one(input logic [OP_W-1:0] op, input logic [DATA_W-1:0] imm,
                            input logic [DATA_W-1:0] pc, input logic [TAG_W-1:0] tag,
                            input bit ua, input bit ub);
      @(negedge clk);
      issue_valid = 1'b1; issue_op = op; issue_imm = imm; issue_pc = pc;
      issue_tag = tag; issue_use_a = ua; issue_use_b = ub;
      @(negedge clk);
      issue_valid = 1'b0;
   endtask

   task automatic resolve(input bit ca, input logic [DATA_W-1:0] va, input logic [TAG_W-1:0] ta,
                          input bit ha, input logic [DATA_W-1:0] ra,
                          input bit cb, input logic [DATA_W-1:0] vb, input logic [TAG_W-1:0] tb,
                          input bit hb, input logic [DATA_W-1:0] rb);
      rf_a_clear = ca; rf_a_val = va; rf_a_tag = ta; rob_a_hit = ha; rob_a_val = ra;
      rf_b_clear = cb; rf_b_val = vb; rf_b_tag = tb; rob_b_hit = hb; rob_b_val = rb;
      @(negedge clk);
      rf_a_clear = 1'b0; rob_a_hit = 1'b0; rf_b_clear = 1'b0; rob_b_hit = 1'b0;
   endtask

   task automatic bcast(input bit from_mem, input logic [1:0] st,
                        input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] v);
      if (from_mem) begin
         mem_res_status = st; mem_res_tag = t; mem_res_val = v;
      end else begin
         alu_res_status = st; alu_res_tag = t; alu_res_val = v;
      end
      @(negedge clk);
      alu_res_status = 2'b00; mem_res_status = 2'b00;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(free_count == CNT_W'(SLOTS), "R1", "free_count", 64'(free_count), 64'(SLOTS));
      chk(disp_op == '0, "R1", "disp_op", 64'(disp_op), 64'h0);
      rst_n = 1'b1;

      // R4 / R2 / R9: both sources from register file, reorder buffer also hits
      issue_one(12'h011, 32'h100, 32'h1000, 5'd1, 1'b1, 1'b1);
      chk(free_count == CNT_W'(SLOTS - 1), "R2", "free after accept", 64'(free_count), 64'(SLOTS - 1));
      expect_item(12'h011, 32'hAAAA_0001, 32'hBBBB_0001, 32'h100, 32'h1000, 5'd1, "R4");
      resolve(1'b1, 32'hAAAA_0001, 5'd0, 1'b1, 32'hDEAD_0001,
              1'b1, 32'hBBBB_0001, 5'd0, 1'b1, 32'hDEAD_0002);
      chk(disp_op == '0, "R9", "no dispatch before second edge", 64'(disp_op), 64'h0);
      idle(2);
      chk(free_count == CNT_W'(SLOTS), "R11", "free after dispatch", 64'(free_count), 64'(SLOTS));

      // R5: sources from reorder buffer
      issue_one(12'h022, 32'h200, 32'h2000, 5'd2, 1'b1, 1'b1);
      expect_item(12'h022, 32'h1234_5678, 32'h8765_4321, 32'h200, 32'h2000, 5'd2, "R5");
      resolve(1'b0, 32'h0, 5'd3, 1'b1, 32'h1234_5678,
              1'b0, 32'h0, 5'd4, 1'b1, 32'h8765_4321);
      idle(2);

      // R8: no source used, values presented are ignored
      issue_one(12'h033, 32'h300, 32'h3000, 5'd3, 1'b0, 1'b0);
      expect_item(12'h033, 32'h0, 32'h0, 32'h300, 32'h3000, 5'd3, "R8");
      resolve(1'b1, 32'h5555_5555, 5'd0, 1'b0, 32'h0, 1'b1, 32'h6666_6666, 5'd0, 1'b0, 32'h0);
      idle(2);

      // R7: wait on tag 3, wrong status ignored, memory broadcast fills
      issue_one(12'h044, 32'h400, 32'h4000, 5'd7, 1'b1, 1'b0);
      resolve(1'b0, 32'h0, 5'd3, 1'b0, 32'h0, 1'b0, 32'h0, 5'd0, 1'b0, 32'h0);
      idle(2);
      chk(disp_op == '0, "R7", "waiting not dispatched", 64'(disp_op), 64'h0);
      chk(free_count == CNT_W'(SLOTS - 1), "R7", "slot still held", 64'(free_count), 64'(SLOTS - 1));
      bcast(1'b0, 2'b01, 5'd3, 32'hBAD0_BAD0);
      bcast(1'b1, 2'b11, 5'd3, 32'hBAD1_BAD1);
      idle(1);
      chk(disp_op == '0, "R7", "bad status ignored", 64'(disp_op), 64'h0);
      chk(free_count == CNT_W'(SLOTS - 1), "R7", "slot held after bad status", 64'(free_count), 64'(SLOTS - 1));
      expect_item(12'h044, 32'hCAFE_0003, 32'h0, 32'h400, 32'h4000, 5'd7, "R7");
      bcast(1'b1, 2'b10, 5'd3, 32'hCAFE_0003);
      idle(2);

      // R6: broadcast in the resolve cycle fills the fresh slot
      issue_one(12'h055, 32'h500, 32'h5000, 5'd8, 1'b0, 1'b1);
      expect_item(12'h055, 32'h0, 32'hF00D_0005, 32'h500, 32'h5000, 5'd8, "R6");
      alu_res_status = 2'b10; alu_res_tag = 5'd5; alu_res_val = 32'hF00D_0005;
      resolve(1'b0, 32'h0, 5'd0, 1'b0, 32'h0, 1'b0, 32'h0, 5'd5, 1'b0, 32'h0);
      alu_res_status = 2'b00;
      idle(2);

      // R9: three waiting on tag 9, lowest slot dispatches first
      issue_one(12'h061, 32'h601, 32'h6001, 5'd10, 1'b1, 1'b0);
      resolve(1'b0, 32'h0, 5'd9, 1'b0, 32'h0, 1'b0, 32'h0, 5'd0, 1'b0, 32'h0);
      issue_one(12'h062, 32'h602, 32'h6002, 5'd11, 1'b1, 1'b0);
      resolve(1'b0, 32'h0, 5'd9, 1'b0, 32'h0, 1'b0, 32'h0, 5'd0, 1'b0, 32'h0);
      issue_one(12'h063, 32'h603, 32'h6003, 5'd12, 1'b1, 1'b0);
      resolve(1'b0, 32'h0, 5'd9, 1'b0, 32'h0, 1'b0, 32'h0, 5'd0, 1'b0, 32'h0);
      chk(free_count == CNT_W'(SLOTS - 3), "R11", "three held", 64'(free_count), 64'(SLOTS - 3));
      expect_item(12'h061, 32'h9999_0009, 32'h0, 32'h601, 32'h6001, 5'd10, "R9");
      expect_item(12'h062, 32'h9999_0009, 32'h0, 32'h602, 32'h6002, 5'd11, "R9");
      expect_item(12'h063, 32'h9999_0009, 32'h0, 32'h603, 32'h6003, 5'd12, "R9");
      bcast(1'b0, 2'b10, 5'd9, 32'h9999_0009);
      idle(5);
      chk(free_count == CNT_W'(SLOTS), "R11", "all returned", 64'(free_count), 64'(SLOTS));
      chk(disp_op == '0, "R10", "idle dispatch", 64'(disp_op), 64'h0);
      chk(disp_a == '0 && disp_tag == '0, "R10", "idle fields", {disp_a, 27'(disp_tag)}, 64'h0);

      // R3: fill every slot, then offer one more
      for (int k = 0; k < SLOTS; k++) begin
         issue_one(OP_W'(12'h100 + k), 32'h700, 32'h7000, 5'(k), 1'b1, 1'b0);
         resolve(1'b0, 32'h0, 5'd20, 1'b0, 32'h0, 1'b0, 32'h0, 5'd0, 1'b0, 32'h0);
      end
      chk(free_count == '0, "R3", "full", 64'(free_count), 64'h0);
      issue_one(12'h0EE, 32'h800, 32'h8000, 5'd30, 1'b0, 1'b0);
      resolve(1'b1, 32'h0, 5'd0, 1'b0, 32'h0, 1'b1, 32'h0, 5'd0, 1'b0, 32'h0);
      idle(2);
      chk(free_count == '0, "R3", "offer ignored", 64'(free_count), 64'h0);

      // R12: flush, then stale tag broadcast dispatches nothing
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      chk(free_count == CNT_W'(SLOTS), "R12", "free after flush", 64'(free_count), 64'(SLOTS));
      bcast(1'b1, 2'b10, 5'd20, 32'h2020_2020);
      idle(3);
      chk(disp_op == '0, "R12", "nothing after flush", 64'(disp_op), 64'h0);
      issue_one(12'h077, 32'h900, 32'h9000, 5'd21, 1'b1, 1'b1);
      expect_item(12'h077, 32'h0000_0077, 32'h0000_0088, 32'h900, 32'h9000, 5'd21, "R12");
      resolve(1'b1, 32'h77, 5'd0, 1'b0, 32'h0, 1'b0, 32'h0, 5'd1, 1'b1, 32'h88);
      idle(3);

      chk(exp_q.size() == 0, "R9", "pending expected items", 64'(exp_q.size()), 64'h0);
      done = 1'b1;
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         chk(1'b0, "R9", "watchdog expired", 64'h0, 64'h1);
         summary();
      end
   end
endmodule